// File: doc/BRIEF.md
# Configurable Logic Slice

This block is a behavioural model of one configurable logic slice made of two halves, a bottom half and a top half. Each half has a 4-input lookup table programmed by a 16-bit configuration word, a carry multiplexer, a sum XOR, an AND gate built from two of its table inputs, and one storage flip-flop. A wide-function multiplexer joins the two table outputs into a function of more inputs. Configuration bits choose where each table output goes: straight out, into the sum XOR, into the wide multiplexer, into the carry select, or into the flip-flop.

The carry enters at the bottom half and leaves from the top half. The bottom carry multiplexer feeds the top one. Each half has a bypass line. A bypass line can leave the slice unchanged, or it can replace the combinational result at its flip-flop. The bottom bypass line selects the wide multiplexer and can seed the carry chain. The top bypass line can act as a synchronous set/reset for both flip-flops.

The configuration is treated as static inputs. Configuring both tables as XOR of inputs 0 and 1, with the AND gate as the generate source and the sum output selected, turns the slice into a 2-bit ripple adder.

Top module: `logic_slice`

## Requirements
- R1: With output select 0 (table), a half's combinational output equals bit {in3,in2,in1,in0} of that half's table word.
- R2: A half's carry out equals its incoming carry when its table output is 1, and its generate value otherwise. The bottom carry out feeds the top half, and the top carry out is `cout`. Output select 3 puts the half's own carry out on its combinational output.
- R3: The carry entering the bottom half is `cin` when `cfg_cy_from_byp` is 0, and `bot_byp` when it is 1.
- R4: The generate select picks the generate value: 0 gives constant 0, 1 gives constant 1, 2 gives the half's bypass line, and 3 gives the AND of that half's inputs 0 and 1.
- R5: With output select 1 (sum), a half's combinational output is its table output XOR the carry entering that half.
- R6: With output select 2 (wide), a half's combinational output is the bottom table output when `bot_byp` is 1, and the top table output when it is 0.
- R7: On a rising clock edge with `ce` high and no set/reset, each flip-flop loads its data input: the half's combinational output when its data-bypass bit is 0, or its bypass line when it is 1. With `ce` low, the flip-flops hold.
- R8: When `cfg_rev_en` and `top_byp` are both 1 at a rising edge, both flip-flops load their configured init values. This happens whatever the value of `ce`.
- R9: `bot_byp_out` and `top_byp_out` always equal `bot_byp` and `top_byp`.
- R10: While `rst_n` is low, each flip-flop holds its configured init value.
- R11: Configured as a 2-bit adder, {`cout`, `top_comb`, `bot_comb`} equals a + b + `cin` for every operand and carry-in combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to init values |
| ce | input | 1 | Clock enable for both flip-flops |
| cin | input | 1 | Carry into the slice |
| bot_lines | input | 4 | Bottom table inputs |
| top_lines | input | 4 | Top table inputs |
| bot_byp | input | 1 | Bottom bypass line |
| top_byp | input | 1 | Top bypass line |
| cfg_bot_table | input | 16 | Bottom table word |
| cfg_top_table | input | 16 | Top table word |
| cfg_bot_osel | input | 2 | Bottom output select (0 table, 1 sum, 2 wide, 3 carry) |
| cfg_top_osel | input | 2 | Top output select |
| cfg_bot_gen | input | 2 | Bottom generate select |
| cfg_top_gen | input | 2 | Top generate select |
| cfg_bot_dbyp | input | 1 | Bottom flip-flop data from bypass line |
| cfg_top_dbyp | input | 1 | Top flip-flop data from bypass line |
| cfg_cy_from_byp | input | 1 | Seed the carry chain from `bot_byp` |
| cfg_rev_en | input | 1 | Let `top_byp` set/reset the flip-flops |
| cfg_bot_init | input | 1 | Bottom flip-flop init value |
| cfg_top_init | input | 1 | Top flip-flop init value |
| bot_comb | output | 1 | Bottom combinational output |
| top_comb | output | 1 | Top combinational output |
| bot_q | output | 1 | Bottom registered output |
| top_q | output | 1 | Top registered output |
| bot_byp_out | output | 1 | Bottom bypass pass-through |
| top_byp_out | output | 1 | Top bypass pass-through |
| cout | output | 1 | Carry out of the slice |

## Verification
The hardest case to reach is a carry that rides the whole chain. That needs both table outputs at 1 at once, with the carry seeded from the bypass line rather than from `cin`. The case gets worse when `ce` is low and a set/reset arrives in the same cycle. Random stimulus redraws every configuration bit and table word each cycle, so all-propagate chains, set/reset with `ce` low, and bypass-fed flip-flops all come up often. Directed runs then force the chain seed source, each generate source, and all 32 adder operand combinations.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int TBL_IN = 4;
    localparam int HALVES = 2;

    typedef enum logic [1:0] {
        OSEL_TABLE = 2'd0,
        OSEL_SUM   = 2'd1,
        OSEL_WIDE  = 2'd2,
        OSEL_CARRY = 2'd3
    } osel_t;

    typedef enum logic [1:0] {
        GEN_ZERO = 2'd0,
        GEN_ONE  = 2'd1,
        GEN_BYP  = 2'd2,
        GEN_AND  = 2'd3
    } gsel_t;
endpackage

// File: rtl/slice_table.sv
module slice_table #(
    parameter int N_IN = 4,
    localparam int W = 1 << N_IN
) (
    input  logic [W-1:0]    word,
    input  logic [N_IN-1:0] sel,
    output logic            y
);
    // any Boolean function of N_IN inputs: index the configuration word
    assign y = word[sel];
endmodule

// File: rtl/slice_carry.sv
module slice_carry
    import slice_pkg::*;
(
    input  gsel_t gen_sel,
    input  logic  prop,
    input  logic  byp,
    input  logic  and_term,
    input  logic  ci,
    output logic  co
);
    logic gen;

    always_comb begin
        unique case (gen_sel)
            GEN_ZERO: gen = 1'b0;
            GEN_ONE:  gen = 1'b1;
            GEN_BYP:  gen = byp;
            GEN_AND:  gen = and_term;
            default:  gen = 1'b0;
        endcase
    end

    // propagate passes the incoming carry, otherwise the generate value
    assign co = prop ? ci : gen;
endmodule

// File: rtl/slice_store.sv
module slice_store (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic rev,
    input  logic init,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= init;
        else if (rev)
            q <= init;
        else if (ce)
            q <= d;
    end
endmodule

// File: rtl/slice_half.sv
module slice_half
    import slice_pkg::*;
#(
    parameter int N_IN = TBL_IN,
    localparam int W = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            rev,
    input  logic [N_IN-1:0] lines,
    input  logic            byp,
    input  logic            carry_in,
    input  logic            wide,
    input  logic [W-1:0]    cfg_word,
    input  osel_t           cfg_osel,
    input  gsel_t           cfg_gen,
    input  logic            cfg_dbyp,
    input  logic            cfg_init,
    output logic            tbl_out,
    output logic            carry_out,
    output logic            comb,
    output logic            q
);
    logic sum;
    logic d_in;

    slice_table #(.N_IN(N_IN)) u_tbl (
        .word (cfg_word),
        .sel  (lines),
        .y    (tbl_out)
    );

    slice_carry u_cy (
        .gen_sel  (cfg_gen),
        .prop     (tbl_out),
        .byp      (byp),
        .and_term (lines[0] & lines[1]),
        .ci       (carry_in),
        .co       (carry_out)
    );

    assign sum = tbl_out ^ carry_in;

    always_comb begin
        unique case (cfg_osel)
            OSEL_TABLE: comb = tbl_out;
            OSEL_SUM:   comb = sum;
            OSEL_WIDE:  comb = wide;
            OSEL_CARRY: comb = carry_out;
            default:    comb = tbl_out;
        endcase
    end

    assign d_in = cfg_dbyp ? byp : comb;

    slice_store u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .rev   (rev),
        .init  (cfg_init),
        .d     (d_in),
        .q     (q)
    );
endmodule

// File: rtl/logic_slice.sv
module logic_slice
    import slice_pkg::*;
#(
    parameter int N_IN = TBL_IN,
    localparam int W = 1 << N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            cin,
    input  logic [N_IN-1:0] bot_lines,
    input  logic [N_IN-1:0] top_lines,
    input  logic            bot_byp,
    input  logic            top_byp,
    input  logic [W-1:0]    cfg_bot_table,
    input  logic [W-1:0]    cfg_top_table,
    input  logic [1:0]      cfg_bot_osel,
    input  logic [1:0]      cfg_top_osel,
    input  logic [1:0]      cfg_bot_gen,
    input  logic [1:0]      cfg_top_gen,
    input  logic            cfg_bot_dbyp,
    input  logic            cfg_top_dbyp,
    input  logic            cfg_cy_from_byp,
    input  logic            cfg_rev_en,
    input  logic            cfg_bot_init,
    input  logic            cfg_top_init,
    output logic            bot_comb,
    output logic            top_comb,
    output logic            bot_q,
    output logic            top_q,
    output logic            bot_byp_out,
    output logic            top_byp_out,
    output logic            cout
);
    logic [N_IN-1:0] lines_a [HALVES];
    logic            byp_a   [HALVES];
    logic [W-1:0]    word_a  [HALVES];
    osel_t           osel_a  [HALVES];
    gsel_t           gen_a   [HALVES];
    logic            dbyp_a  [HALVES];
    logic            init_a  [HALVES];
    logic            tbl_a   [HALVES];
    logic            comb_a  [HALVES];
    logic            q_a     [HALVES];
    logic [HALVES:0] chain;
    logic            wide;
    logic            rev;
    logic            bot_tbl, top_tbl, base_carry;

    assign lines_a[0] = bot_lines;            assign lines_a[1] = top_lines;
    assign byp_a[0]   = bot_byp;              assign byp_a[1]   = top_byp;
    assign word_a[0]  = cfg_bot_table;        assign word_a[1]  = cfg_top_table;
    assign osel_a[0]  = osel_t'(cfg_bot_osel); assign osel_a[1] = osel_t'(cfg_top_osel);
    assign gen_a[0]   = gsel_t'(cfg_bot_gen);  assign gen_a[1]  = gsel_t'(cfg_top_gen);
    assign dbyp_a[0]  = cfg_bot_dbyp;         assign dbyp_a[1]  = cfg_top_dbyp;
    assign init_a[0]  = cfg_bot_init;         assign init_a[1]  = cfg_top_init;

    // chain seed: carry-in or bottom bypass line
    assign chain[0] = cfg_cy_from_byp ? bot_byp : cin;
    // wide-function multiplexer, bottom bypass line as select
    assign wide = bot_byp ? tbl_a[0] : tbl_a[1];
    // top bypass line as shared synchronous set/reset
    assign rev  = cfg_rev_en & top_byp;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        slice_half #(.N_IN(N_IN)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .ce        (ce),
            .rev       (rev),
            .lines     (lines_a[h]),
            .byp       (byp_a[h]),
            .carry_in  (chain[h]),
            .wide      (wide),
            .cfg_word  (word_a[h]),
            .cfg_osel  (osel_a[h]),
            .cfg_gen   (gen_a[h]),
            .cfg_dbyp  (dbyp_a[h]),
            .cfg_init  (init_a[h]),
            .tbl_out   (tbl_a[h]),
            .carry_out (chain[h+1]),
            .comb      (comb_a[h]),
            .q         (q_a[h])
        );
    end

    assign bot_tbl     = tbl_a[0];
    assign top_tbl     = tbl_a[1];
    assign base_carry  = chain[0];
    assign bot_comb    = comb_a[0];
    assign top_comb    = comb_a[1];
    assign bot_q       = q_a[0];
    assign top_q       = q_a[1];
    assign bot_byp_out = bot_byp;
    assign top_byp_out = top_byp;
    assign cout        = chain[HALVES];
endmodule

// File: rtl/slice_chk.sv
module slice_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce,
    input logic       rev_en,
    input logic       rev_line,
    input logic       dbyp_bot,
    input logic       byp_bot,
    input logic       init_bot,
    input logic       init_top,
    input logic       q_bot,
    input logic       q_top,
    input logic       prop_bot,
    input logic       prop_top,
    input logic       base_carry,
    input logic       cout,
    input logic [1:0] osel_bot,
    input logic       comb_bot
);
    // R7
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !(rev_en && rev_line)) |=> ($stable(q_bot) && $stable(q_top)));

    // R8
    q_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_en && rev_line) |=> (q_bot == $past(init_bot) && q_top == $past(init_top)));

    // R7
    q_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !(rev_en && rev_line) && dbyp_bot) |=> (q_bot == $past(byp_bot)));

    // R2
    carry_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_bot && prop_top) |-> (cout == base_carry));

    // R5
    bot_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osel_bot == 2'd1) |-> (comb_bot == (prop_bot ^ base_carry)));
endmodule

bind logic_slice slice_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (ce),
    .rev_en     (cfg_rev_en),
    .rev_line   (top_byp),
    .dbyp_bot   (cfg_bot_dbyp),
    .byp_bot    (bot_byp),
    .init_bot   (cfg_bot_init),
    .init_top   (cfg_top_init),
    .q_bot      (bot_q),
    .q_top      (top_q),
    .prop_bot   (bot_tbl),
    .prop_top   (top_tbl),
    .base_carry (base_carry),
    .cout       (cout),
    .osel_bot   (cfg_bot_osel),
    .comb_bot   (bot_comb)
);

// File: tb/sim_logic_slice.sv
module sim_logic_slice;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, cin = 1'b0, bb = 1'b0, tbyp = 1'b0;
    logic [3:0] bl = '0, tl = '0;
    logic [15:0] cbt = '0, ctt = '0;
    logic [1:0] cbo = '0, cto = '0, cbg = '0, ctg = '0;
    logic cbd = 1'b0, ctd = 1'b0, cyb = 1'b0, rev_en = 1'b0, bi = 1'b1, ti = 1'b0;
    logic bot_comb, top_comb, bot_q, top_q, bot_byp_out, top_byp_out, cout;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic mq_b, mq_t;

    always #4 clk = ~clk;

    logic_slice u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .cin(cin),
        .bot_lines(bl), .top_lines(tl), .bot_byp(bb), .top_byp(tbyp),
        .cfg_bot_table(cbt), .cfg_top_table(ctt),
        .cfg_bot_osel(cbo), .cfg_top_osel(cto),
        .cfg_bot_gen(cbg), .cfg_top_gen(ctg),
        .cfg_bot_dbyp(cbd), .cfg_top_dbyp(ctd),
        .cfg_cy_from_byp(cyb), .cfg_rev_en(rev_en),
        .cfg_bot_init(bi), .cfg_top_init(ti),
        .bot_comb(bot_comb), .top_comb(top_comb), .bot_q(bot_q), .top_q(top_q),
        .bot_byp_out(bot_byp_out), .top_byp_out(top_byp_out), .cout(cout)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic gen_val(input logic [1:0] s, input logic byp, input logic andv);
        case (s)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return byp;
            default: return andv;
        endcase
    endfunction

    function automatic logic out_val(input logic [1:0] s, input logic t, input logic sm,
                                     input logic w, input logic c);
        case (s)
            2'd0: return t;
            2'd1: return sm;
            2'd2: return w;
            default: return c;
        endcase
    endfunction

    // {bot_comb, top_comb, cout, bot_d, top_d}
    function automatic logic [4:0] model();
        logic c0, c1, co, tb, tt, w, bc, tc;
        c0 = cyb ? bb : cin;
        tb = cbt[bl];
        tt = ctt[tl];
        c1 = tb ? c0 : gen_val(cbg, bb, bl[0] & bl[1]);
        co = tt ? c1 : gen_val(ctg, tbyp, tl[0] & tl[1]);
        w  = bb ? tb : tt;
        bc = out_val(cbo, tb, tb ^ c0, w, c1);
        tc = out_val(cto, tt, tt ^ c1, w, co);
        return {bc, tc, co, cbd ? bb : bc, ctd ? tbyp : tc};
    endfunction

    function automatic string bot_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R1 bot table";
            2'd1: return "R5 bot sum";
            2'd2: return "R6 bot wide";
            default: return "R2 bot carry";
        endcase
    endfunction

    // one cycle: drive already set; check comb, step the clock, check q
    task automatic cycle_check();
        logic [4:0] e;
        #1;
        e = model();
        check(bot_tag(cbo), {2'b0, bot_comb}, {2'b0, e[4]});
        check("R1/R5/R6 top comb", {2'b0, top_comb}, {2'b0, e[3]});
        check("R2 cout", {2'b0, cout}, {2'b0, e[2]});
        check("R9 bypass out", {1'b0, bot_byp_out, top_byp_out}, {1'b0, bb, tbyp});
        if (rev_en && tbyp) begin
            mq_b = bi; mq_t = ti;
        end else if (ce) begin
            mq_b = e[1]; mq_t = e[0];
        end
        @(posedge clk);
        #1;
        check((rev_en && tbyp) ? "R8 set/reset q" : "R7 q update",
              {1'b0, bot_q, top_q}, {1'b0, mq_b, mq_t});
    endtask

    initial begin
        void'($urandom(32'h1c5e_2b07));
        // R10 reset state
        repeat (2) @(posedge clk);
        #1;
        check("R10 reset init", {1'b0, bot_q, top_q}, 3'b010);
        mq_b = 1'b1; mq_t = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            {ce, cin, bb, tbyp} = 4'($urandom);
            bl = 4'($urandom); tl = 4'($urandom);
            cbt = 16'($urandom); ctt = 16'($urandom);
            {cbo, cto, cbg, ctg} = 8'($urandom);
            {cbd, ctd, cyb, bi, ti} = 5'($urandom);
            rev_en = ($urandom % 4) == 0;
            cycle_check();
        end

        // directed R3: both halves propagate, chain seeded from bypass line
        rev_en = 1'b0; ce = 1'b0;
        cbt = 16'hFFFF; ctt = 16'hFFFF; cyb = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            {bb, cin} = 2'(k);
            #1;
            check("R3 seed from bypass", {2'b0, cout}, {2'b0, bb});
        end
        @(negedge clk);
        cyb = 1'b0; cin = 1'b1; bb = 1'b0;
        #1;
        check("R3 seed from cin", {2'b0, cout}, 3'b001);

        // directed R4: bottom generates, top propagates
        cbt = 16'h0000; ctt = 16'hFFFF; cin = 1'b0;
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            cbg = 2'(g); bb = 1'b1; bl = 4'b0011;
            #1;
            check("R4 generate source", {2'b0, cout}, {2'b0, (g == 0) ? 1'b0 : 1'b1});
            bb = 1'b0; bl = 4'b0001;
            #1;
            check("R4 generate source low", {2'b0, cout}, {2'b0, (g == 1) ? 1'b1 : 1'b0});
        end

        // directed R11: 2-bit adder, a on line 0, b on line 1 of each half
        cbt = 16'h6666; ctt = 16'h6666; cbg = 2'd3; ctg = 2'd3;
        cbo = 2'd1; cto = 2'd1; cyb = 1'b0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 2; c++) begin
                    @(negedge clk);
                    bl = {2'b00, b[0], a[0]};
                    tl = {2'b00, b[1], a[1]};
                    cin = c[0];
                    #1;
                    check("R11 adder", {cout, top_comb, bot_comb}, 3'(a + b + c));
                end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule